// File: doc/BRIEF.md
# Machine-Cycle External Bus Sequencer

This block produces the twelve-tick machine-cycle frame of a classic eight-bit microcontroller. It drives the external program-memory and data-memory bus for each instruction class the core reports. One clock is one oscillator tick. A machine cycle walks through six states of two phases each: ST1_PH1, ST1_PH2, ST2_PH1, and so on up to ST6_PH2, with tick indices 0 to 11 in that order. A second state machine runs on top of the tick frame. Its states are MC_IDLE, MC_FIRST and MC_SECOND. It leaves MC_IDLE for MC_FIRST after one machine cycle. It goes from MC_FIRST to MC_SECOND when the latched class needs two cycles, and otherwise stays in MC_FIRST. It always goes from MC_SECOND back to MC_FIRST. Each of these moves happens at the end of ST6_PH2.

Program bytes are read twice per machine cycle. A read comes either from the external bus, using the address strobe and the active-low program-read strobe, or from an internal ROM port. For every read, the sequencer tells the core whether the byte is kept (the program counter advances) or dropped (the counter holds). For external-data transfer classes, the second machine cycle carries no program fetch. It carries a data read or data write at the pointer address instead.

The core presents `ins_class`, `xptr` and `xwr_byte` after it sees the opcode. The sequencer latches them once per instruction.

Top module: `bus_cycle_seq`

## Requirements
- R1: A machine cycle is exactly 12 clocks; the MC state changes only when entering ST1_PH1, so an instruction of N cycles starts the next one 12·N clocks later with the address strobe high.
- R2: Synchronous reset puts the tick at ST1_PH1 and the MC state at MC_IDLE, and sets `prog_ctr` to 0. During reset and during the following idle machine cycle, the address strobe is low, all three strobes are high and `ad_oe` is 0.
- R3: Outside the quiet second cycle of a transfer, the address strobe is high in ST1_PH1 and ST4_PH1. In those ticks, `ad_out` carries the low byte of `prog_ctr` and `addr_hi` carries its high byte. The program byte is read in the following tick (ST1_PH2 or ST4_PH2).
- R4: `prog_rd_n` is low only in a read tick whose fetch address is external. With `int_rom_en` = 0, every fetch is external.
- R5: With `int_rom_en` = 1, an address below INT_ROM_BYTES is read from `irom_byte` with `prog_rd_n` held high. An address at or above INT_ROM_BYTES is read externally.
- R6: Class 0 (two-byte, one cycle) keeps both reads and advances `prog_ctr` by 2.
- R7: Class 1 (one-byte, one cycle) keeps the ST1_PH2 read and drops the ST4_PH2 read. `prog_ctr` advances by 1, and the dropped read re-reads the next address.
- R8: Class 2 (one-byte, two cycles) keeps the first read and drops the other three. `prog_ctr` advances by 1.
- R9: In the first cycle, classes 3 and 4 keep one read and drop one. They also raise the address strobe in ST5_PH1 and ST5_PH2. They drive the low byte of `xptr` on `ad_out` from ST5_PH1 to ST6_PH1, and drive the high byte of `xptr` on `addr_hi` from ST5_PH1 through ST4_PH1 of the second cycle.
- R10: In the second cycle of classes 3 and 4, neither the address strobe nor `prog_rd_n` is asserted. For class 3, `data_rd_n` is low from ST6_PH2 of cycle one through ST4_PH1 of cycle two. `ad_in` is captured at the end of ST4_PH1 and appears on `xdata`, with `xdata_valid` high for one clock.
- R11: Class 4 uses the same window as class 3 but drives `data_wr_n` low instead, with `xwr_byte` on `ad_out` and `ad_oe` = 1 for the whole window. `data_rd_n` and `data_wr_n` are never low together.
- R12: `ins_class`, `xptr` and `xwr_byte` are sampled only at the end of ST2_PH1 of MC_FIRST. Later changes within the instruction have no effect.
- R13: `byte_keep` or `byte_drop` is high for the one clock after a read tick, with the byte on `fetch_byte`; the two are never high together. `ad_oe` is 0 whenever `prog_rd_n` or `data_rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst | input | 1 | Synchronous reset, active high |
| int_rom_en | input | 1 | 1: addresses below INT_ROM_BYTES come from the internal ROM port |
| ins_class | input | 3 | Instruction class code 0 to 4 |
| xptr | input | 16 | External data pointer |
| xwr_byte | input | 8 | Byte for an external data write |
| irom_byte | input | 8 | Internal ROM byte at `prog_ctr` |
| ad_in | input | 8 | Low port input (instruction or data byte) |
| addr_strobe | output | 1 | Address latch strobe, high while `ad_out` holds an address |
| prog_rd_n | output | 1 | External program read strobe, active low |
| data_rd_n | output | 1 | External data read strobe, active low |
| data_wr_n | output | 1 | External data write strobe, active low |
| ad_out | output | 8 | Low port output: address low byte or write data |
| ad_oe | output | 1 | Low port output enable |
| addr_hi | output | 8 | High address byte |
| prog_ctr | output | 16 | Program counter |
| byte_keep | output | 1 | Last read byte is kept |
| byte_drop | output | 1 | Last read byte is dropped |
| fetch_byte | output | 8 | Last read program byte |
| xdata | output | 8 | Byte from an external data read |
| xdata_valid | output | 1 | `xdata` updated this clock |

## Verification
A vector table runs every class with several pointer and write values. It checks the strobe pattern of each tick, the keep and drop counts, the counter step and the byte contents. This separates one-cycle from two-cycle schedules and read transfers from write transfers. Every instruction changes its class and pointer inputs after the sampling tick, so any late sampling would show up as a wrong schedule. A run of internal fetches ends with a two-byte instruction whose operand crosses the internal-ROM limit, which tells the internal byte source from the external one within a single cycle. A reset during a data read shows that the strobes return to idle at once.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [3:0] {
        ST1_PH1, ST1_PH2, ST2_PH1, ST2_PH2, ST3_PH1, ST3_PH2,
        ST4_PH1, ST4_PH2, ST5_PH1, ST5_PH2, ST6_PH1, ST6_PH2
    } tick_e;

    typedef enum logic [1:0] {
        MC_IDLE, MC_FIRST, MC_SECOND
    } mcyc_e;

    typedef enum logic [2:0] {
        CL_TWO_BYTE = 3'd0,
        CL_ONE_BYTE = 3'd1,
        CL_LONG     = 3'd2,
        CL_XRD      = 3'd3,
        CL_XWR      = 3'd4
    } iclass_e;

    function automatic logic is_xfer(iclass_e c);
        return (c == CL_XRD) || (c == CL_XWR);
    endfunction

    function automatic logic is_two_cycle(iclass_e c);
        return (c == CL_LONG) || is_xfer(c);
    endfunction

endpackage

// File: rtl/busseq_timebase.sv
module busseq_timebase
    import busseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_e tick
);

    tick_e tick_d;

    always_comb begin
        unique case (tick)
            ST6_PH2: tick_d = ST1_PH1;
            default: tick_d = tick_e'(tick + 4'd1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tick <= ST1_PH1;
        else     tick <= tick_d;
    end

    // R1
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick == ST6_PH2) |=> (tick == ST1_PH1));

endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
    import busseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 16,
    parameter int INT_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  tick_e             tick,
    input  logic              int_rom_en,
    input  logic [2:0]        ins_class,
    input  logic [ADDR_W-1:0] xptr,
    input  logic [DATA_W-1:0] xwr_byte,
    input  logic [DATA_W-1:0] irom_byte,
    input  logic [DATA_W-1:0] ad_in,
    output mcyc_e             mcyc,
    output iclass_e           cls_q,
    output logic [ADDR_W-1:0] xptr_q,
    output logic [DATA_W-1:0] xwr_q,
    output logic [ADDR_W-1:0] prog_ctr,
    output logic              int_fetch,
    output logic              byte_keep,
    output logic              byte_drop,
    output logic [DATA_W-1:0] fetch_byte,
    output logic [DATA_W-1:0] xdata,
    output logic              xdata_valid
);

    localparam logic [ADDR_W:0] INT_LIM = (ADDR_W+1)'(INT_BYTES);

    mcyc_e mcyc_d;
    logic  read_tick, slot_live, keep_now, drop_now, latch_now, cap_now;

    // machine-cycle state register
    always_ff @(posedge clk) begin
        if (rst) mcyc <= MC_IDLE;
        else     mcyc <= mcyc_d;
    end

    // machine-cycle transitions, taken only at the end of ST6_PH2
    always_comb begin
        mcyc_d = mcyc;
        if (tick == ST6_PH2) begin
            unique case (mcyc)
                MC_IDLE:   mcyc_d = MC_FIRST;
                MC_FIRST:  mcyc_d = is_two_cycle(cls_q) ? MC_SECOND : MC_FIRST;
                MC_SECOND: mcyc_d = MC_FIRST;
                default:   mcyc_d = MC_IDLE;
            endcase
        end
    end

    // fetch decisions for the current tick
    always_comb begin
        read_tick = (tick == ST1_PH2) || (tick == ST4_PH2);
        slot_live = (mcyc == MC_FIRST) || ((mcyc == MC_SECOND) && (cls_q == CL_LONG));
        keep_now  = read_tick && (mcyc == MC_FIRST) &&
                    ((tick == ST1_PH2) || (cls_q == CL_TWO_BYTE));
        drop_now  = read_tick && slot_live && !keep_now;
        latch_now = (mcyc == MC_FIRST) && (tick == ST2_PH1);
        cap_now   = (mcyc == MC_SECOND) && (tick == ST4_PH1) && (cls_q == CL_XRD);
        int_fetch = int_rom_en && ({1'b0, prog_ctr} < INT_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_ctr    <= '0;
            cls_q       <= CL_ONE_BYTE;
            xptr_q      <= '0;
            xwr_q       <= '0;
            byte_keep   <= 1'b0;
            byte_drop   <= 1'b0;
            fetch_byte  <= '0;
            xdata       <= '0;
            xdata_valid <= 1'b0;
        end else begin
            byte_keep   <= keep_now;
            byte_drop   <= drop_now;
            xdata_valid <= cap_now;
            if (keep_now) prog_ctr <= prog_ctr + ADDR_W'(1);
            if (keep_now || drop_now) fetch_byte <= int_fetch ? irom_byte : ad_in;
            if (latch_now) begin
                cls_q  <= iclass_e'(ins_class);
                xptr_q <= xptr;
                xwr_q  <= xwr_byte;
            end
            if (cap_now) xdata <= ad_in;
        end
    end

    // R1
    mcyc_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mcyc != $past(mcyc)) |-> (tick == ST1_PH1));

    // R6
    keep_step_chk: assert property (@(posedge clk) disable iff (rst)
        byte_keep |-> (prog_ctr == $past(prog_ctr) + ADDR_W'(1)));

    // R7
    drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        byte_drop |-> (prog_ctr == $past(prog_ctr)));

    // R13
    keep_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(byte_keep && byte_drop));

endmodule

// File: rtl/busseq_bus.sv
module busseq_bus
    import busseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  tick_e             tick,
    input  mcyc_e             mcyc,
    input  iclass_e           cls,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] xptr,
    input  logic [DATA_W-1:0] xwr,
    input  logic              int_fetch,
    output logic              addr_strobe,
    output logic              prog_rd_n,
    output logic              data_rd_n,
    output logic              data_wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] addr_hi
);

    logic running, xfer, quiet, x_first;
    logic addr_slot, read_slot, x_ale, x_lo, x_hi, strobe;

    always_comb begin
        running   = (mcyc != MC_IDLE);
        xfer      = is_xfer(cls);
        quiet     = (mcyc == MC_SECOND) && xfer;
        x_first   = (mcyc == MC_FIRST) && xfer;
        addr_slot = running && !quiet && ((tick == ST1_PH1) || (tick == ST4_PH1));
        read_slot = running && !quiet && ((tick == ST1_PH2) || (tick == ST4_PH2));
        x_ale     = x_first && ((tick == ST5_PH1) || (tick == ST5_PH2));
        x_lo      = x_first && (tick >= ST5_PH1) && (tick <= ST6_PH1);
        x_hi      = (x_first && (tick >= ST5_PH1)) || (quiet && (tick <= ST4_PH1));
        strobe    = (x_first && (tick == ST6_PH2)) || (quiet && (tick <= ST4_PH1));
    end

    always_comb begin
        addr_strobe = addr_slot || x_ale;
        prog_rd_n   = !(read_slot && !int_fetch);
        data_rd_n   = !(strobe && (cls == CL_XRD));
        data_wr_n   = !(strobe && (cls == CL_XWR));
        ad_oe       = addr_slot || x_lo || (strobe && (cls == CL_XWR));
        if (addr_slot)  ad_out = pc[DATA_W-1:0];
        else if (x_lo)  ad_out = xptr[DATA_W-1:0];
        else            ad_out = xwr;
        addr_hi     = x_hi ? xptr[ADDR_W-1:DATA_W] : pc[ADDR_W-1:DATA_W];
    end

    // R10
    xfer_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_rd_n || !data_wr_n) |-> (!addr_strobe && prog_rd_n));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!data_rd_n && !data_wr_n));

    // R13
    bus_contend_chk: assert property (@(posedge clk) disable iff (rst)
        (!prog_rd_n || !data_rd_n) |-> !ad_oe);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mcyc == MC_IDLE) |-> (!addr_strobe && prog_rd_n && data_rd_n && data_wr_n && !ad_oe));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import busseq_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                int_rom_en,
    input  logic [2:0]          ins_class,
    input  logic [2*DATA_W-1:0] xptr,
    input  logic [DATA_W-1:0]   xwr_byte,
    input  logic [DATA_W-1:0]   irom_byte,
    input  logic [DATA_W-1:0]   ad_in,
    output logic                addr_strobe,
    output logic                prog_rd_n,
    output logic                data_rd_n,
    output logic                data_wr_n,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [DATA_W-1:0]   addr_hi,
    output logic [2*DATA_W-1:0] prog_ctr,
    output logic                byte_keep,
    output logic                byte_drop,
    output logic [DATA_W-1:0]   fetch_byte,
    output logic [DATA_W-1:0]   xdata,
    output logic                xdata_valid
);

    localparam int ADDR_W = 2 * DATA_W;

    tick_e             tick;
    mcyc_e             mcyc;
    iclass_e           cls_q;
    logic [ADDR_W-1:0] xptr_q;
    logic [DATA_W-1:0] xwr_q;
    logic              int_fetch;

    busseq_timebase u_time (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    busseq_ctrl #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .INT_BYTES (INT_ROM_BYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .int_rom_en  (int_rom_en),
        .ins_class   (ins_class),
        .xptr        (xptr),
        .xwr_byte    (xwr_byte),
        .irom_byte   (irom_byte),
        .ad_in       (ad_in),
        .mcyc        (mcyc),
        .cls_q       (cls_q),
        .xptr_q      (xptr_q),
        .xwr_q       (xwr_q),
        .prog_ctr    (prog_ctr),
        .int_fetch   (int_fetch),
        .byte_keep   (byte_keep),
        .byte_drop   (byte_drop),
        .fetch_byte  (fetch_byte),
        .xdata       (xdata),
        .xdata_valid (xdata_valid)
    );

    busseq_bus #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .mcyc        (mcyc),
        .cls         (cls_q),
        .pc          (prog_ctr),
        .xptr        (xptr_q),
        .xwr         (xwr_q),
        .int_fetch   (int_fetch),
        .addr_strobe (addr_strobe),
        .prog_rd_n   (prog_rd_n),
        .data_rd_n   (data_rd_n),
        .data_wr_n   (data_wr_n),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .addr_hi     (addr_hi)
    );

endmodule

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

    localparam int INT_LIM = 16;

    typedef struct packed {
        logic [2:0]  cls;
        logic [1:0]  ncyc;
        logic [15:0] xp;
        logic [7:0]  wd;
        logic [23:0] ale;
        logic [23:0] prd;
        logic [23:0] drd;
        logic [23:0] dwr;
        logic [2:0]  keeps;
        logic [2:0]  drops;
        logic [1:0]  adv;
    } entry_t;

    localparam entry_t VEC [8] = '{
        '{3'd0, 2'd1, 16'h0000, 8'h00, 24'h000041, 24'h000082, 24'h0, 24'h0, 3'd2, 3'd0, 2'd2},
        '{3'd1, 2'd1, 16'h0000, 8'h00, 24'h000041, 24'h000082, 24'h0, 24'h0, 3'd1, 3'd1, 2'd1},
        '{3'd3, 2'd2, 16'h12A5, 8'h00, 24'h000341, 24'h000082, 24'h07F800, 24'h0, 3'd1, 3'd1, 2'd1},
        '{3'd2, 2'd2, 16'h0000, 8'h00, 24'h041041, 24'h082082, 24'h0, 24'h0, 3'd1, 3'd3, 2'd1},
        '{3'd4, 2'd2, 16'hFF00, 8'h5A, 24'h000341, 24'h000082, 24'h0, 24'h07F800, 3'd1, 3'd1, 2'd1},
        '{3'd0, 2'd1, 16'h0000, 8'h00, 24'h000041, 24'h000082, 24'h0, 24'h0, 3'd2, 3'd0, 2'd2},
        '{3'd3, 2'd2, 16'h00FF, 8'h00, 24'h000341, 24'h000082, 24'h07F800, 24'h0, 3'd1, 3'd1, 2'd1},
        '{3'd4, 2'd2, 16'h8001, 8'hC3, 24'h000341, 24'h000082, 24'h0, 24'h07F800, 3'd1, 3'd1, 2'd1}
    };
    localparam entry_t E_INT  = '{3'd1, 2'd1, 16'h0, 8'h0, 24'h000041, 24'h000000, 24'h0, 24'h0, 3'd1, 3'd1, 2'd1};
    localparam entry_t E_EDGE = '{3'd0, 2'd1, 16'h0, 8'h0, 24'h000041, 24'h000080, 24'h0, 24'h0, 3'd2, 3'd0, 2'd2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        int_rom_en = 1'b0;
    logic [2:0]  ins_class = 3'd1;
    logic [15:0] xptr = 16'h0;
    logic [7:0]  xwr_byte = 8'h0;
    logic [7:0]  irom_byte;
    logic [7:0]  ad_in;
    logic        addr_strobe, prog_rd_n, data_rd_n, data_wr_n, ad_oe;
    logic [7:0]  ad_out, addr_hi, fetch_byte, xdata;
    logic [15:0] prog_ctr;
    logic        byte_keep, byte_drop, xdata_valid;
    logic [7:0]  lat = 8'h0;
    logic [15:0] exp_pc = 16'h0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_cycle_seq #(.DATA_W(8), .INT_ROM_BYTES(INT_LIM)) i_bus_cycle_seq (
        .clk(clk), .rst(rst), .int_rom_en(int_rom_en), .ins_class(ins_class),
        .xptr(xptr), .xwr_byte(xwr_byte), .irom_byte(irom_byte), .ad_in(ad_in),
        .addr_strobe(addr_strobe), .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n),
        .data_wr_n(data_wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .prog_ctr(prog_ctr), .byte_keep(byte_keep), .byte_drop(byte_drop),
        .fetch_byte(fetch_byte), .xdata(xdata), .xdata_valid(xdata_valid)
    );

    function automatic logic [7:0] rom_b(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] xram_b(logic [15:0] a);
        return a[7:0] + a[15:8] + 8'd1;
    endfunction

    function automatic logic [7:0] src_b(logic [15:0] a);
        return (int_rom_en && (a < 16'(INT_LIM))) ? ~a[7:0] : rom_b(a);
    endfunction

    // external address latch and memories
    always @(posedge clk) if (addr_strobe) lat <= ad_out;
    assign irom_byte = ~prog_ctr[7:0];
    always_comb begin
        if (!prog_rd_n)      ad_in = rom_b({addr_hi, lat});
        else if (!data_rd_n) ad_in = xram_b({addr_hi, lat});
        else                 ad_in = 8'h00;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_pc = 16'h0;
        chk(addr_strobe == 1'b0, "R2 strobe low after reset", 32'(addr_strobe), 0);
        chk({prog_rd_n, data_rd_n, data_wr_n} == 3'b111, "R2 read/write strobes high",
            32'({prog_rd_n, data_rd_n, data_wr_n}), 7);
        chk(ad_oe == 1'b0, "R2 port not driven", 32'(ad_oe), 0);
        chk(prog_ctr == 16'h0, "R2 counter zero", 32'(prog_ctr), 0);
        begin
            logic [11:0] act_m = '0;
            for (int i = 0; i < 12; i++) begin
                act_m[i] = addr_strobe | !prog_rd_n | !data_rd_n | !data_wr_n | ad_oe;
                @(negedge clk);
            end
            chk(act_m == 12'h0, "R2 idle machine cycle", 32'(act_m), 0);
        end
        chk(addr_strobe == 1'b1, "R1 R2 first fetch after 12 ticks", 32'(addr_strobe), 1);
    endtask

    task automatic run_instr(input entry_t e);
        logic [23:0] m_ale = '0, m_prd = '0, m_drd = '0, m_dwr = '0;
        int          nk = 0, nd = 0, nv = 0;
        bit          wr_ok = 1'b1, rd_ok = 1'b1, adr_ok = 1'b1;
        logic [15:0] pc0 = prog_ctr;
        ins_class = e.cls;
        xptr      = e.xp;
        xwr_byte  = e.wd;
        for (int i = 0; i < int'(e.ncyc) * 12; i++) begin
            if (i == 4) begin
                ins_class = e.cls ^ 3'd3;
                xptr      = ~e.xp;
                xwr_byte  = ~e.wd;
            end
            m_ale[i] = addr_strobe;
            m_prd[i] = !prog_rd_n;
            m_drd[i] = !data_rd_n;
            m_dwr[i] = !data_wr_n;
            if (byte_keep) begin
                chk(fetch_byte == src_b(exp_pc), "R3 R5 kept byte", 32'(fetch_byte), 32'(src_b(exp_pc)));
                exp_pc++;
                nk++;
            end
            if (byte_drop) begin
                chk(fetch_byte == src_b(exp_pc), "R7 dropped byte re-read", 32'(fetch_byte), 32'(src_b(exp_pc)));
                nd++;
            end
            if (xdata_valid) begin
                nv++;
                chk(xdata == xram_b(e.xp), "R10 captured data", 32'(xdata), 32'(xram_b(e.xp)));
            end
            if (!data_wr_n && !(ad_oe && ad_out == e.wd && addr_hi == e.xp[15:8])) wr_ok = 1'b0;
            if (!data_rd_n && !(!ad_oe && addr_hi == e.xp[15:8])) rd_ok = 1'b0;
            if (i == 11 && e.cls >= 3'd3) adr_ok = ({addr_hi, lat} == e.xp);
            @(negedge clk);
        end
        chk(m_ale == e.ale, "R3 R9 R12 address strobe pattern", 32'(m_ale), 32'(e.ale));
        chk(m_prd == e.prd, "R4 R5 R10 program read pattern", 32'(m_prd), 32'(e.prd));
        chk(m_drd == e.drd, "R10 R12 data read pattern", 32'(m_drd), 32'(e.drd));
        chk(m_dwr == e.dwr, "R11 R12 data write pattern", 32'(m_dwr), 32'(e.dwr));
        chk(nk == int'(e.keeps), "R6 R7 R8 R9 keep count", 32'(nk), 32'(e.keeps));
        chk(nd == int'(e.drops), "R7 R8 R9 drop count", 32'(nd), 32'(e.drops));
        chk(prog_ctr == pc0 + 16'(e.adv), "R6 R7 R8 counter step", 32'(prog_ctr), 32'(pc0 + 16'(e.adv)));
        chk(nv == ((e.cls == 3'd3) ? 1 : 0), "R10 capture pulse count", 32'(nv), 32'(e.cls == 3'd3));
        chk(wr_ok && rd_ok, "R11 transfer window port contents", 32'({wr_ok, rd_ok}), 3);
        chk(adr_ok, "R9 pointer address latched", 32'({addr_hi, lat}), 32'(e.xp));
        chk(addr_strobe && ad_out == prog_ctr[7:0], "R1 R3 next instruction start",
            32'({addr_strobe, ad_out}), 32'({1'b1, prog_ctr[7:0]}));
    endtask

    initial begin
        do_reset();
        // internal fetches below the limit, then a two-byte instruction crossing it
        int_rom_en = 1'b1;
        for (int k = 0; k < 15; k++) run_instr(E_INT);
        run_instr(E_EDGE);
        // table walk, all external
        int_rom_en = 1'b0;
        do_reset();
        for (int k = 0; k < 8; k++) run_instr(VEC[k]);
        // reset in the middle of a data read
        ins_class = 3'd3;
        xptr = 16'h4321;
        for (int i = 0; i < 14; i++) @(negedge clk);
        chk(data_rd_n == 1'b0, "R10 read strobe mid-transfer", 32'(data_rd_n), 0);
        rst = 1'b1;
        @(negedge clk);
        chk({data_rd_n, prog_rd_n, addr_strobe} == 3'b110, "R2 reset ends transfer",
            32'({data_rd_n, prog_rd_n, addr_strobe}), 6);
        chk(prog_ctr == 16'h0, "R2 reset counter mid-transfer", 32'(prog_ctr), 0);
        rst = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule